// File: doc/BRIEF.md
# Grouped Overflow-Freezing Counter Bank

This block counts pulses on a row of negative-true event inputs, one counter per input, and freezes the whole bank when any counter wraps. The counters are organised in pairs. Each pair has an enable latch, and a single master latch gates every pair. Each input is brought into the clock domain through two flops. A count is taken on the high-to-low transition that follows, so an input that is held low yields only one count.

A counter that wraps from all-ones to zero does four things in the same cycle: it pulses `frz_drive_o`, it sets the sticky overflow flag that feeds interrupt logic, it clears the master latch, and it lets the wrapped value settle at zero. Several banks can share one wired-OR freeze net. Each bank drives the net through `frz_drive_o` and senses it on `frz_line_i`, so an overflow anywhere stops all of them. A strap input joins the two counters of each pair into one double-width counter. The lower-numbered counter is the low half.

Software-side decoding is outside this block. It sees level-free one-cycle command strobes, a pair select, and a combinational readout of the selected pair.

Top module: `ofcb_top`

## Requirements
- R1: After reset every counter reads zero, the master latch and all pair enables are set, and the overflow flag is clear.
- R2: Each input counts once per high-to-low transition seen after two synchronising flops. A level held low for many cycles adds exactly one.
- R3: `grp_dis_i` clears the enable of the pair chosen by `grp_sel_i`. Only that pair stops counting input pulses. `grp_en_all_i` sets every pair enable again.
- R4: When a counter at all-ones takes an increment, it wraps to zero. In that same cycle `frz_drive_o` is high for one cycle. At the same edge the master latch clears and the overflow flag sets. After that, input pulses change no counter.
- R5: `frz_line_i` high for one cycle clears the master latch at the next edge, and input pulses then stop being counted.
- R6: `master_en_i` sets the master latch, unless an overflow or `frz_line_i` happens in the same cycle, in which case the latch clears.
- R7: With `inhibit_en_i` high, `inhibit_i` high stops input pulses from counting. With `inhibit_en_i` low, `inhibit_i` has no effect.
- R8: `incr_all_i` adds one to every counter in each cycle it is high. This holds regardless of the pair enables, the master latch and the inhibit.
- R9: `rd_data_o` shows the pair chosen by `grp_sel_i`. Counter 2g is on bits CNT_W-1:0 and counter 2g+1 is on bits 2*CNT_W-1:CNT_W, each with its MSB at the top.
- R10: With `wide_mode_i` high, each pair is a single 2*CNT_W-bit counter. It counts only the lower input of the pair, and the upper input is ignored. The carry passes from the low half to the high half, and overflow is raised only when the full-width counter wraps.
- R11: `clr_grp_i` zeroes the selected pair and clears the flag. `clr_all_i` zeroes all counters and clears the flag. `ovf_clr_i` clears only the flag. A clear takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_ni | input | NUM_CH | Event inputs, active low |
| wide_mode_i | input | 1 | Strap that joins each pair into one double-width counter |
| grp_sel_i | input | GSEL_W | Pair select for readout and addressed commands |
| grp_dis_i | input | 1 | Clear enable of selected pair |
| grp_en_all_i | input | 1 | Set all pair enables |
| master_en_i | input | 1 | Set master count latch |
| clr_grp_i | input | 1 | Zero selected pair and flag |
| clr_all_i | input | 1 | Zero all counters and flag |
| ovf_clr_i | input | 1 | Clear overflow flag |
| incr_all_i | input | 1 | Add one to every counter |
| inhibit_i | input | 1 | Global count inhibit |
| inhibit_en_i | input | 1 | Lets inhibit_i take effect |
| frz_line_i | input | 1 | Sensed shared freeze net |
| rd_data_o | output | 2*CNT_W | Selected pair readout |
| grp_en_o | output | NUM_GRP | Pair enable latches |
| master_en_o | output | 1 | Master count latch |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| frz_drive_o | output | 1 | One-cycle freeze request to shared net |

## Verification
A wrong master or pair latch does not show up on its own. It shows up as missing counts, or as counts where none belong, on the next pulse that the bench sends and then reads back through `rd_data_o`. The latch outputs are also compared directly with the model after every command. A bad carry or wrap check shows up only at the boundary: 4095 to 0 in split mode, and at the low-half wrap and the full-width wrap in joined mode. For that reason those boundaries are approached with `incr_all_i` and checked in the cycle where they occur, together with the one-cycle `frz_drive_o` count. Random pulse masks with random enables and inhibit settings compare every counter with the bench model every few iterations.

// File: rtl/ofcb_pkg.sv
package ofcb_pkg;
  typedef enum logic {
    PAIR_SPLIT  = 1'b0,
    PAIR_JOINED = 1'b1
  } pair_mode_e;
endpackage

// File: rtl/ofcb_in_sync.sv
module ofcb_in_sync #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pulse_ni,
  output logic [NUM_CH-1:0] fall_o
);
  logic [NUM_CH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pulse_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // asserted level is low: count on high-to-low of the synchronised line
  assign fall_o = s3_q & ~s2_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o & $past(fall_o)) == '0); // R2
endmodule

// File: rtl/ofcb_cnt_pair.sv
module ofcb_cnt_pair
  import ofcb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pair_mode_e       mode_i,
  input  logic [1:0]       fall_i,
  input  logic             en_i,
  input  logic             incr_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] lo_q, hi_q;
  logic lo_max, hi_max, inc_lo, inc_hi, joined;

  assign joined = (mode_i == PAIR_JOINED);
  assign lo_max = (lo_q == CNT_MAX);
  assign hi_max = (hi_q == CNT_MAX);
  assign inc_lo = incr_i | (fall_i[0] & en_i);
  assign inc_hi = joined ? (inc_lo & lo_max) : (incr_i | (fall_i[1] & en_i));

  always_comb begin
    if (clr_i)       ovf_o = 1'b0;
    else if (joined) ovf_o = inc_lo & lo_max & hi_max;
    else             ovf_o = (inc_lo & lo_max) | (inc_hi & hi_max);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (inc_lo) lo_q <= lo_q + 1'b1;
      if (inc_hi) hi_q <= hi_q + 1'b1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_SPLIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PAIR_SPLIT && !clr_i) |=>
      (lo_q == $past(lo_q) || lo_q == CNT_W'($past(lo_q) + 1'b1))); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !incr_i && !clr_i) |=> ($stable(lo_q) && $stable(hi_q))); // R4
  AST_JOIN_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PAIR_JOINED && !clr_i && !lo_max) |=> $stable(hi_q)); // R10
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lo_q == '0 && hi_q == '0)); // R11
endmodule

// File: rtl/ofcb_ctrl.sv
module ofcb_ctrl #(
  parameter int NUM_GRP = 4,
  parameter int GSEL_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GSEL_W-1:0]  grp_sel_i,
  input  logic               grp_dis_i,
  input  logic               grp_en_all_i,
  input  logic               master_en_i,
  input  logic               clr_grp_i,
  input  logic               clr_all_i,
  input  logic               ovf_clr_i,
  input  logic               inhibit_i,
  input  logic               inhibit_en_i,
  input  logic               frz_line_i,
  input  logic               ovf_any_i,
  output logic [NUM_GRP-1:0] cnt_en_o,
  output logic [NUM_GRP-1:0] grp_en_o,
  output logic               master_o,
  output logic               flag_o
);
  logic [NUM_GRP-1:0] grp_q;
  logic master_q, flag_q, inh_act;

  assign inh_act = inhibit_i & inhibit_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b1;
      flag_q   <= 1'b0;
    end else begin
      // freeze wins over re-enable
      if (ovf_any_i || frz_line_i) master_q <= 1'b0;
      else if (master_en_i)        master_q <= 1'b1;
      // a new overflow wins over any clear
      if (ovf_any_i)                                flag_q <= 1'b1;
      else if (clr_all_i || clr_grp_i || ovf_clr_i) flag_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         grp_q[g] <= 1'b1;
      else if (grp_dis_i && grp_sel_i == GSEL_W'(g))        grp_q[g] <= 1'b0;
      else if (grp_en_all_i)                               grp_q[g] <= 1'b1;
    end
    assign cnt_en_o[g] = master_q & grp_q[g] & ~inh_act;
  end

  assign grp_en_o = grp_q;
  assign master_o = master_q;
  assign flag_o   = flag_q;

  AST_OVF_STOPS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_any_i |=> !master_q); // R4
  AST_OVF_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_any_i |=> flag_q); // R4
  AST_FRZ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_line_i |=> !master_q); // R5
  AST_MASTER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_en_i && !ovf_any_i && !frz_line_i) |=> master_q); // R6
endmodule

// File: rtl/ofcb_top.sv
module ofcb_top
  import ofcb_pkg::*;
#(
  parameter  int NUM_CH  = 8,
  parameter  int CNT_W   = 12,
  localparam int NUM_GRP = NUM_CH / 2,
  localparam int GSEL_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    pulse_ni,
  input  logic                 wide_mode_i,
  input  logic [GSEL_W-1:0]    grp_sel_i,
  input  logic                 grp_dis_i,
  input  logic                 grp_en_all_i,
  input  logic                 master_en_i,
  input  logic                 clr_grp_i,
  input  logic                 clr_all_i,
  input  logic                 ovf_clr_i,
  input  logic                 incr_all_i,
  input  logic                 inhibit_i,
  input  logic                 inhibit_en_i,
  input  logic                 frz_line_i,
  output logic [2*CNT_W-1:0]   rd_data_o,
  output logic [NUM_GRP-1:0]   grp_en_o,
  output logic                 master_en_o,
  output logic                 ovf_flag_o,
  output logic                 frz_drive_o
);
  logic [NUM_CH-1:0]  fall;
  logic [NUM_GRP-1:0] cnt_en, pair_ovf;
  logic [2*CNT_W-1:0] pair_data [NUM_GRP];
  logic               ovf_any;
  pair_mode_e         mode;

  assign mode    = pair_mode_e'(wide_mode_i);
  assign ovf_any = |pair_ovf;

  ofcb_in_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_ni (pulse_ni),
    .fall_o   (fall)
  );

  ofcb_ctrl #(.NUM_GRP(NUM_GRP), .GSEL_W(GSEL_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grp_sel_i    (grp_sel_i),
    .grp_dis_i    (grp_dis_i),
    .grp_en_all_i (grp_en_all_i),
    .master_en_i  (master_en_i),
    .clr_grp_i    (clr_grp_i),
    .clr_all_i    (clr_all_i),
    .ovf_clr_i    (ovf_clr_i),
    .inhibit_i    (inhibit_i),
    .inhibit_en_i (inhibit_en_i),
    .frz_line_i   (frz_line_i),
    .ovf_any_i    (ovf_any),
    .cnt_en_o     (cnt_en),
    .grp_en_o     (grp_en_o),
    .master_o     (master_en_o),
    .flag_o       (ovf_flag_o)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
    logic clr_pair;
    logic [CNT_W-1:0] lo, hi;
    assign clr_pair = clr_all_i | (clr_grp_i & (grp_sel_i == GSEL_W'(g)));

    ofcb_cnt_pair #(.CNT_W(CNT_W)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .fall_i (fall[2*g+1:2*g]),
      .en_i   (cnt_en[g]),
      .incr_i (incr_all_i),
      .clr_i  (clr_pair),
      .lo_o   (lo),
      .hi_o   (hi),
      .ovf_o  (pair_ovf[g])
    );
    assign pair_data[g] = {hi, lo};
  end

  assign rd_data_o   = pair_data[grp_sel_i];
  assign frz_drive_o = ovf_any;

  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_drive_o && !master_en_i) |=> !master_en_o); // R4
endmodule

// File: tb/ofcb_top_test.sv
`timescale 1ns/1ps
module ofcb_top_test;
  localparam int NCH = 8;
  localparam int W   = 12;
  localparam int MX  = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] pulse_n = '1;
  logic [1:0] sel = '0;
  logic dis = 0, en_all = 0, men = 0, cgrp = 0, call = 0, oclr = 0, incr = 0;
  logic inh = 0, inh_en = 0, frz = 0;
  logic [2*W-1:0] rd;
  logic [3:0] gen;
  logic mst, flg, fdrv;
  logic [7:0] rd_w;
  logic [3:0] gen_w;
  logic mst_w, flg_w, fdrv_w;

  int checks = 0, fails = 0, fdrv_cnt = 0;
  int model [NCH];
  logic m_master = 1, m_flag = 0;
  logic [3:0] m_grp = 4'hF;

  always #2.5 clk = ~clk;

  ofcb_top #(.NUM_CH(NCH), .CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_ni(pulse_n), .wide_mode_i(1'b0),
    .grp_sel_i(sel), .grp_dis_i(dis), .grp_en_all_i(en_all), .master_en_i(men),
    .clr_grp_i(cgrp), .clr_all_i(call), .ovf_clr_i(oclr), .incr_all_i(incr),
    .inhibit_i(inh), .inhibit_en_i(inh_en), .frz_line_i(frz),
    .rd_data_o(rd), .grp_en_o(gen), .master_en_o(mst), .ovf_flag_o(flg),
    .frz_drive_o(fdrv));

  ofcb_top #(.NUM_CH(NCH), .CNT_W(4)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .pulse_ni(pulse_n), .wide_mode_i(1'b1),
    .grp_sel_i(sel), .grp_dis_i(dis), .grp_en_all_i(en_all), .master_en_i(men),
    .clr_grp_i(cgrp), .clr_all_i(call), .ovf_clr_i(oclr), .incr_all_i(incr),
    .inhibit_i(inh), .inhibit_en_i(inh_en), .frz_line_i(frz),
    .rd_data_o(rd_w), .grp_en_o(gen_w), .master_en_o(mst_w), .ovf_flag_o(flg_w),
    .frz_drive_o(fdrv_w));

  always @(negedge clk) if (rst_n && fdrv) fdrv_cnt++;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] exp_pair(input int g);
    return {W'(model[2*g+1]), W'(model[2*g])};
  endfunction

  task automatic check_all(input string req);
    for (int g = 0; g < 4; g++) begin
      sel = 2'(g);
      #1;
      check(rd == exp_pair(g), req, rd, exp_pair(g));
    end
    check(mst == m_master, {req, " master"}, mst, m_master);
    check(flg == m_flag, {req, " flag"}, flg, m_flag);
    check(gen == m_grp, {req, " grp_en"}, gen, m_grp);
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic apply_inc(input logic [NCH-1:0] mask, input logic gated);
    logic wrap = 0;
    for (int c = 0; c < NCH; c++)
      if (mask[c] && (!gated || (m_master && m_grp[c/2] && !(inh && inh_en)))) begin
        if (model[c] == MX) wrap = 1;
        model[c] = (model[c] + 1) & MX;
      end
    if (wrap) begin m_master = 0; m_flag = 1; end
  endtask

  task automatic pulse(input logic [NCH-1:0] mask, input int low_cyc);
    @(negedge clk) pulse_n = ~mask;
    repeat (low_cyc) @(negedge clk);
    pulse_n = '1;
    repeat (4) @(negedge clk);
    apply_inc(mask, 1'b1);
  endtask

  task automatic incr_n(input int n);
    @(negedge clk) incr = 1;
    repeat (n) @(negedge clk);
    incr = 0;
    for (int i = 0; i < n; i++) apply_inc('1, 1'b0);
  endtask

  task automatic clear_all_model;
    strobe(call);
    for (int c = 0; c < NCH; c++) model[c] = 0;
    m_flag = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) model[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_all("R1 reset");

    // R2 single and long pulses, R9 distinct layout
    pulse(8'b0000_0001, 2);
    pulse(8'b0000_0010, 12);
    pulse(8'b0000_0010, 2);
    pulse(8'b1000_0000, 3);
    check_all("R2 R9 pulse count");

    // R3 disable pair 1 only
    sel = 2'd1; strobe(dis); m_grp[1] = 0;
    pulse('1, 2);
    check_all("R3 pair disable");
    strobe(en_all); m_grp = 4'hF;
    pulse('1, 2);
    check_all("R3 enable all");

    // R7 inhibit
    inh = 1; inh_en = 0;
    pulse(8'b0101_0101, 2);
    check_all("R7 inhibit ignored");
    inh_en = 1;
    pulse('1, 2);
    check_all("R7 inhibit blocks");
    inh = 0; inh_en = 0;

    // R11 clear pair, clear beats increment
    sel = 2'd2; strobe(cgrp); model[4] = 0; model[5] = 0; m_flag = 0;
    check_all("R11 clear pair");
    @(negedge clk) begin sel = 2'd3; incr = 1; cgrp = 1; end
    @(negedge clk) begin incr = 0; cgrp = 0; end
    apply_inc('1, 1'b0); model[6] = 0; model[7] = 0;
    check_all("R11 clear over incr");

    // random phase
    for (int it = 0; it < 240; it++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 0) begin sel = r[5:4]; strobe(dis); m_grp[r[5:4]] = 0; end
      if (r[3:0] == 1) begin strobe(en_all); m_grp = 4'hF; end
      inh = r[6]; inh_en = r[7];
      pulse(r[15:8], 2 + int'(r[17:16]));
      if (it % 20 == 19) check_all("R2 R3 R7 random");
    end
    inh = 0; inh_en = 0;
    strobe(en_all); m_grp = 4'hF;

    // R4 overflow freeze
    clear_all_model();
    pulse(8'b0010_0000, 2); pulse(8'b0010_0000, 2); pulse(8'b0010_0000, 2);
    incr_n(MX - 3);
    fdrv_cnt = 0;
    check_all("R8 R4 before wrap");
    pulse(8'b0010_0000, 2);
    check_all("R4 wrap freezes");
    check(fdrv_cnt == 1, "R4 frz_drive cycles", fdrv_cnt, 1);
    pulse(8'b0000_0001, 2);
    check_all("R4 frozen pulse");
    incr_n(1);
    check_all("R8 incr while frozen");
    strobe(oclr); m_flag = 0;
    check_all("R11 flag clear only");

    // R6 conflict and set
    @(negedge clk) begin men = 1; frz = 1; end
    @(negedge clk) begin men = 0; frz = 0; end
    check_all("R6 freeze beats enable");
    strobe(men); m_master = 1;
    check_all("R6 master set");

    // R5 shared freeze line
    strobe(frz); m_master = 0;
    pulse(8'b0000_0010, 2);
    check_all("R5 frz line");
    strobe(men); m_master = 1;

    // R10 joined mode on narrow instance
    clear_all_model();
    strobe(en_all);
    sel = 2'd0;
    incr_n(16);
    #1 check(rd_w == 8'h10, "R10 carry", rd_w, 8'h10);
    check(flg_w == 0, "R10 no half ovf", flg_w, 0);
    pulse(8'b0000_0010, 2);
    #1 check(rd_w == 8'h10, "R10 upper input ignored", rd_w, 8'h10);
    pulse(8'b0000_0001, 2);
    #1 check(rd_w == 8'h11, "R10 lower input", rd_w, 8'h11);
    incr_n(238);
    #1 check(rd_w == 8'hFF, "R10 full", rd_w, 8'hFF);
    check(flg_w == 0 && mst_w == 1, "R10 before wrap", {flg_w, mst_w}, 2'b01);
    incr_n(1);
    #1 check(rd_w == 8'h00, "R10 full wrap", rd_w, 8'h00);
    check(flg_w == 1 && mst_w == 0, "R10 wrap freeze", {flg_w, mst_w}, 2'b10);

    finish_run();
  end
endmodule